// File: doc/BRIEF.md
# Pseudo-Random Scan Stimulus Source with XOR Spreading Network

This block produces test stimulus for a large set of parallel scan chains from a single short linear feedback shift register. The register runs a maximal-length sequence. A fixed network of three-input XOR gates expands its sixteen bits into thirty-two distinct chain-input streams, so more chains are fed than the register has bits.

A mode input selects, for every chain, whether the chain input is taken from the generated network or from the matching external scan-in pin. The register advances on every shift cycle in either mode. While shifting is paused, the register and every chain input hold their values. A seed-load input places a chosen starting state in the register. An all-zero seed, which would lock the register, is replaced by a fixed nonzero default.

Top module: `lfsr_stim_spreader`

## Requirements
- R1: Starting from any nonzero state, the register returns to that state after exactly 65535 shift cycles and not before.
- R2: One shift step maps state s to n with n[15] = s[0] and n[i] = s[i+1] XOR (M[i] AND s[0]) for i < 15, where the feedback mask M = 16'hB400.
- R3: In generated mode (`gen_mode` = 1), a shift cycle loads `chain_si[k]` with s[a] ^ s[b] ^ s[c] of the state s held before that edge. Here g = k / 16, a = k mod 16, b = (a + g + 1) mod 16 and c = (a + 2g + 3) mod 16.
- R4: Over one full period, no two of the 32 chain-input streams are identical.
- R5: In external mode (`gen_mode` = 0), a shift cycle loads `chain_si[k]` with `ext_si[k]`.
- R6: The register advances on every shift cycle whatever the mode, so external-mode cycles still consume sequence steps.
- R7: With `seed_load` high, the register takes `seed` at the next edge and `chain_si` holds. `seed_load` has priority over `shift_en`.
- R8: A `seed` of zero loads the default state 16'hACE1 instead.
- R9: With `shift_en` and `seed_load` both low, the register and `chain_si` hold, whatever `gen_mode` and `ext_si` do.
- R10: While `rst_n` is low, `chain_si` is 0 and the register holds 16'hACE1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seed_load | input | 1 | Load `seed` into the register |
| seed | input | 16 | Starting state; zero is replaced by the default |
| shift_en | input | 1 | Shift cycle: advance register, update chain inputs |
| gen_mode | input | 1 | 1 = generated bits, 0 = external scan-in |
| ext_si | input | 32 | External scan-in values, one per chain |
| chain_si | output | 32 | Registered scan-chain input values |

## Verification
On every cycle, the assertions check the following behaviours:
- the register never holds zero;
- it always moves on a shift cycle;
- seed loads, including the zero-seed substitution, land in the next cycle;
- a pause or a load freezes the chain inputs;
- external mode copies the scan-in pins.

Only the bench's scenarios can show the properties that depend on the sequence itself: the exact step function, the exact tap sets of the spreading network, the full 65535-cycle period, and the mutual distinctness of all 32 streams over that period. The bench checks these against its own model of the register and the network.

// File: rtl/stim_spreader_pkg.sv
package stim_spreader_pkg;

  localparam int unsigned DEF_LFSR_W = 16;
  localparam int unsigned DEF_CHAINS = 32;
  localparam logic [15:0] DEF_FB_MASK = 16'hB400;
  localparam logic [15:0] DEF_SEED    = 16'hACE1;

  // Tap index for chain k: which = 0,1,2 picks the three distinct taps.
  // Group g = k / w shifts the spacing so every chain has its own tap set.
  function automatic int unsigned tap_index(input int unsigned k,
                                            input int unsigned w,
                                            input int unsigned which);
    int unsigned g;
    int unsigned base;
    g    = k / w;
    base = k % w;
    case (which)
      0:       tap_index = base;
      1:       tap_index = (base + g + 1) % w;
      default: tap_index = (base + 2 * g + 3) % w;
    endcase
  endfunction

endpackage

// File: rtl/spreader_lfsr.sv
module spreader_lfsr #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] FB_MASK = 16'hB400,
  parameter logic [W-1:0] DEF_SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] seed,
  input  logic         adv,
  output logic [W-1:0] state
);

  // Right-shifting Galois step: bit 0 feeds back through the mask.
  function automatic logic [W-1:0] next_state(input logic [W-1:0] s);
    next_state = (s >> 1) ^ (s[0] ? FB_MASK : '0);
  endfunction

  // An all-zero seed would lock the register; substitute the default.
  function automatic logic [W-1:0] legal_seed(input logic [W-1:0] s);
    legal_seed = (s == '0) ? DEF_SEED : s;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)    state <= DEF_SEED;
    else if (load) state <= legal_seed(seed);
    else if (adv)  state <= next_state(state);
  end

endmodule

// File: rtl/spreader_xor_net.sv
module spreader_xor_net
  import stim_spreader_pkg::*;
#(
  parameter int unsigned W = 16,
  parameter int unsigned CHAINS = 32
) (
  input  logic [W-1:0]      state,
  output logic [CHAINS-1:0] bits
);

  for (genvar k = 0; k < CHAINS; k++) begin : g_chain
    localparam int unsigned TA = tap_index(k, W, 0);
    localparam int unsigned TB = tap_index(k, W, 1);
    localparam int unsigned TC = tap_index(k, W, 2);
    assign bits[k] = state[TA] ^ state[TB] ^ state[TC];
  end

endmodule

// File: rtl/spreader_chain_bank.sv
module spreader_chain_bank #(
  parameter int unsigned CHAINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              gen_mode,
  input  logic [CHAINS-1:0] gen_bits,
  input  logic [CHAINS-1:0] ext_bits,
  output logic [CHAINS-1:0] q
);

  for (genvar k = 0; k < CHAINS; k++) begin : g_mux
    logic pick;
    assign pick = gen_mode ? gen_bits[k] : ext_bits[k];
    always_ff @(posedge clk) begin
      if (!rst_n)       q[k] <= 1'b0;
      else if (capture) q[k] <= pick;
    end
  end

endmodule

// File: rtl/lfsr_stim_spreader.sv
module lfsr_stim_spreader
  import stim_spreader_pkg::*;
#(
  parameter int unsigned LFSR_W = DEF_LFSR_W,
  parameter int unsigned CHAINS = DEF_CHAINS,
  parameter logic [LFSR_W-1:0] FB_MASK = DEF_FB_MASK,
  parameter logic [LFSR_W-1:0] SEED_DEFAULT = DEF_SEED
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seed_load,
  input  logic [LFSR_W-1:0] seed,
  input  logic              shift_en,
  input  logic              gen_mode,
  input  logic [CHAINS-1:0] ext_si,
  output logic [CHAINS-1:0] chain_si
);

  // Named internal events for the checker.
  logic              shift_cycle;
  logic [LFSR_W-1:0] lfsr_state;
  logic [CHAINS-1:0] gen_bits;

  assign shift_cycle = shift_en & ~seed_load;

  spreader_lfsr #(
    .W(LFSR_W), .FB_MASK(FB_MASK), .DEF_SEED(SEED_DEFAULT)
  ) u_lfsr (
    .clk(clk), .rst_n(rst_n), .load(seed_load), .seed(seed),
    .adv(shift_cycle), .state(lfsr_state)
  );

  spreader_xor_net #(.W(LFSR_W), .CHAINS(CHAINS)) u_net (
    .state(lfsr_state), .bits(gen_bits)
  );

  spreader_chain_bank #(.CHAINS(CHAINS)) u_bank (
    .clk(clk), .rst_n(rst_n), .capture(shift_cycle), .gen_mode(gen_mode),
    .gen_bits(gen_bits), .ext_bits(ext_si), .q(chain_si)
  );

endmodule

// File: rtl/stim_spreader_chk.sv
module stim_spreader_chk #(
  parameter int unsigned W = 16,
  parameter int unsigned CHAINS = 32,
  parameter logic [W-1:0] SEED_DEFAULT = 16'hACE1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              seed_load,
  input logic [W-1:0]      seed,
  input logic              shift_en,
  input logic              gen_mode,
  input logic [CHAINS-1:0] ext_si,
  input logic [CHAINS-1:0] chain_si,
  input logic [W-1:0]      lfsr_state
);

  assert_state_nonzero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_state != '0);

  assert_moves_on_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !seed_load) |=> lfsr_state != $past(lfsr_state));

  assert_seed_taken_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (seed_load && seed != '0) |=> lfsr_state == $past(seed));

  assert_load_freezes_out_R7: assert property (@(posedge clk) disable iff (!rst_n)
    seed_load |=> $stable(chain_si));

  assert_zero_seed_sub_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (seed_load && seed == '0) |=> lfsr_state == SEED_DEFAULT);

  assert_pause_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && !seed_load) |=> ($stable(chain_si) && $stable(lfsr_state)));

  assert_ext_copy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !seed_load && !gen_mode) |=> chain_si == $past(ext_si));

endmodule

bind lfsr_stim_spreader stim_spreader_chk #(
  .W(LFSR_W), .CHAINS(CHAINS), .SEED_DEFAULT(SEED_DEFAULT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed(seed),
  .shift_en(shift_en), .gen_mode(gen_mode), .ext_si(ext_si),
  .chain_si(chain_si), .lfsr_state(lfsr_state)
);

// File: tb/sim_lfsr_stim_spreader.sv
`timescale 1ns/1ps
module sim_lfsr_stim_spreader;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        seed_load = 1'b0;
  logic [15:0] seed = '0;
  logic        shift_en = 1'b0;
  logic        gen_mode = 1'b1;
  logic [31:0] ext_si = '0;
  logic [31:0] chain_si;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  logic [15:0] ms;   // bench model of the register

  always #4 clk = ~clk;   // 125 MHz

  lfsr_stim_spreader u0 (
    .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed(seed),
    .shift_en(shift_en), .gen_mode(gen_mode), .ext_si(ext_si),
    .chain_si(chain_si)
  );

  // Step per R2, written bit by bit.
  function automatic logic [15:0] m_step(input logic [15:0] s);
    logic [15:0] m;
    logic [15:0] n;
    m = 16'hB400;
    for (int i = 0; i < 16; i++)
      n[i] = (i == 15) ? s[0] : (s[i+1] ^ (m[i] & s[0]));
    return n;
  endfunction

  // Chain taps per R3.
  function automatic logic [31:0] m_net(input logic [15:0] s);
    logic [31:0] o;
    for (int k = 0; k < 32; k++) begin
      int g, a, b, c;
      g = k / 16; a = k % 16;
      b = (a + g + 1) % 16; c = (a + 2 * g + 3) % 16;
      o[k] = s[a] ^ s[b] ^ s[c];
    end
    return o;
  endfunction

  // Seed table: {seed written, state expected after load}.
  localparam logic [31:0] SEED_TBL [6] = '{
    {16'h0001, 16'h0001}, {16'h0000, 16'hACE1}, {16'hFFFF, 16'hFFFF},
    {16'h8000, 16'h8000}, {16'h1234, 16'h1234}, {16'h0000, 16'hACE1}
  };

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      summary();
    end
  end

  initial begin
    logic [31:0] held, first, last;
    logic [31:0] diff [32];
    int per_bad, period;
    logic [15:0] w;

    // R10: reset state
    repeat (3) tick();
    check("R10 reset out", chain_si, 32'h0);
    rst_n = 1'b1; shift_en = 1'b1; gen_mode = 1'b1;
    tick();
    check("R10 reset state", chain_si, m_net(16'hACE1));
    ms = m_step(16'hACE1);

    // R7/R8: seed table walk
    for (int t = 0; t < 6; t++) begin
      held = chain_si;
      seed_load = 1'b1; shift_en = 1'b0; seed = SEED_TBL[t][31:16];
      tick();
      seed_load = 1'b0;
      check("R7 load holds out", chain_si, held);
      shift_en = 1'b1;
      tick();
      shift_en = 1'b0;
      check((SEED_TBL[t][31:16] == 0) ? "R8 zero seed" : "R7 seed load",
            chain_si, m_net(SEED_TBL[t][15:0]));
      ms = m_step(SEED_TBL[t][15:0]);
    end

    // R7: load wins over shift
    held = chain_si;
    seed_load = 1'b1; shift_en = 1'b1; seed = 16'h00FF;
    tick();
    seed_load = 1'b0;
    check("R7 priority hold", chain_si, held);
    tick();
    check("R7 priority load", chain_si, m_net(16'h00FF));
    ms = m_step(16'h00FF);

    // R9: pause while mode and scan-in wiggle
    shift_en = 1'b0;
    held = chain_si;
    for (int i = 0; i < 3; i++) begin
      gen_mode = i[0]; ext_si = 32'hA5A5_0000 ^ i;
      tick();
      check("R9 pause hold", chain_si, held);
    end
    gen_mode = 1'b1; shift_en = 1'b1;
    tick();
    check("R9 state held", chain_si, m_net(ms));
    ms = m_step(ms);

    // R5/R6: external mode, register keeps advancing
    gen_mode = 1'b0;
    for (int i = 0; i < 4; i++) begin
      ext_si = (i == 0) ? 32'h0 : (i == 1) ? 32'hFFFF_FFFF :
               (i == 2) ? 32'h8000_0001 : 32'h1357_9BDF;
      tick();
      check("R5 ext copy", chain_si, ext_si);
      ms = m_step(ms);
    end
    gen_mode = 1'b1;
    tick();
    check("R6 advance in ext mode", chain_si, m_net(ms));
    ms = m_step(ms);

    // R1/R2/R3/R4: full period from seed 1
    shift_en = 1'b0; seed_load = 1'b1; seed = 16'h0001;
    tick();
    seed_load = 1'b0; shift_en = 1'b1;
    ms = 16'h0001;
    per_bad = 0; first = '0; last = '0;
    for (int k = 0; k < 32; k++) diff[k] = '0;
    for (int i = 0; i <= 65535; i++) begin
      tick();
      if (chain_si !== m_net(ms)) begin
        if (per_bad == 0) begin held = chain_si; last = m_net(ms); end
        per_bad++;
      end
      if (i == 0) first = chain_si;
      if (i < 65535)
        for (int k = 0; k < 32; k++) diff[k] |= chain_si ^ {32{chain_si[k]}};
      else
        check("R1 repeats after 65535", chain_si, first);
      ms = m_step(ms);
    end
    shift_en = 1'b0;
    n_cmp++;
    if (per_bad != 0) begin
      n_bad++;
      $display("FAIL R2/R3 sequence: got %h expected %h (%0d bad cycles)",
               held, last, per_bad);
    end
    for (int k = 0; k < 32; k++)
      check("R4 distinct streams", diff[k], ~(32'h1 << k));
    w = 16'h0001; period = 0;
    do begin w = m_step(w); period++; end while (w != 16'h0001 && period < 70000);
    check("R1 model period", period, 65535);

    summary();
  end

endmodule